// File: doc/BRIEF.md
# Cache Flush Instruction Decoder

This block judges one instruction that has already been fetched and split into fields. The instruction is a cache-line flush that writes back any modified data and then invalidates the line. The block is given the prefix flags, the two opcode bytes, the ModRM byte, the current execution mode, a feature-enable bit and the effective address with its segment attributes. From these it decides whether the instruction belongs to it. If so, it either issues a flush request carrying the address or reports the fault that has to be raised.

The caller presents one instruction per cycle with `inValid` high. One cycle later the block gives its verdict on registered outputs. The verdict is a flush strobe with the address, a fault strobe with a fault kind and its exception vector, or no strobe when the encoding is not this instruction. Upstream logic generates the address and does the paging walk. A page fault therefore arrives as a flag, and segment-limit violations arrive already computed.

Top module: `flush_insn_decoder`

## Requirements
- R1: The instruction is claimed only when `pfxOpSize`=1, `opByte0`=8'h0F, `opByte1`=8'hAE, ModRM bits [5:3]=3'b111 and ModRM bits [7:6] differ from 2'b11. Any other encoding produces neither strobe in the following cycle.
- R2: A claimed instruction raises undefined-opcode when `featEn`=0, when `pfxLock`=1, or when `pfxRepz` or `pfxRepnz` is 1. This fault is `faultKind`=1 with vector 6, and it outranks every other fault.
- R3: Modes are encoded on `execMode` as 0 = real, 1 = virtual-8086, 2 = protected or compatibility, 3 = 64-bit. In modes 0 and 1, an address above 16'hFFFF raises general-protection: `faultKind`=2, vector 13.
- R4: In mode 3, an address whose bits [63:47] are not all equal is non-canonical. It raises stack fault (`faultKind`=3, vector 12) when `segId`=2 (the stack segment), and general-protection (kind 2, vector 13) for any other segment.
- R5: In mode 2, a fault is raised when `segLimitFault`=1, or when `segReadable`=0 and `segExecOnly`=0. The fault is stack fault when `segId`=2 and general-protection for any other segment.
- R6: In mode 2, a segment with `segReadable`=0 and `segExecOnly`=1 is accepted, and the instruction flushes.
- R7: When no undefined-opcode fault or address fault applies and `pageFault`=1, the block raises page fault (`faultKind`=4, vector 14) in modes 1, 2 and 3. In mode 0, `pageFault` is ignored.
- R8: A claimed instruction with no fault raises `flushValid`, and `flushAddr` equals the effective address. `flushAddr` keeps its value in every cycle in which `flushValid` is low.
- R9: The outputs are registered. A verdict appears in the cycle after `inValid`=1, and both strobes are low in the cycle after `inValid`=0. `flushValid` and `faultValid` are never high together, and when `faultValid` is low, `faultKind` and `faultVector` read 0.
- R10: While reset is asserted and after it is released, all outputs are 0.
- R11: In modes 0, 1 and 3, the inputs `segLimitFault`, `segReadable` and `segExecOnly` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An instruction is presented this cycle |
| pfxOpSize | input | 1 | Operand-size prefix (66h) present |
| pfxLock | input | 1 | LOCK prefix present |
| pfxRepz | input | 1 | F3h repeat prefix present |
| pfxRepnz | input | 1 | F2h repeat prefix present |
| opByte0 | input | 8 | First opcode byte |
| opByte1 | input | 8 | Second opcode byte |
| modrm | input | 8 | ModRM byte |
| execMode | input | 2 | Execution mode (0 real, 1 v86, 2 protected/compat, 3 64-bit) |
| featEn | input | 1 | Feature-enable bit for this instruction |
| effAddr | input | ADDR_W | Effective (linear) address of the byte operand |
| segId | input | 3 | Segment of the operand (2 = stack segment) |
| segLimitFault | input | 1 | Segment limit or null-selector violation from address generation |
| segReadable | input | 1 | Operand segment permits reads |
| segExecOnly | input | 1 | Operand segment is an execute-only code segment |
| pageFault | input | 1 | Translation of the address faulted |
| flushValid | output | 1 | Flush request issued |
| flushAddr | output | ADDR_W | Address of the line to flush |
| faultValid | output | 1 | Fault reported |
| faultKind | output | 3 | 1 undefined-opcode, 2 general-protection, 3 stack, 4 page |
| faultVector | output | 8 | Exception vector of the reported fault |

## Verification
The hardest cases to reach are those where several faults apply at once. Examples are a non-canonical address that also carries a page fault and a lock prefix, or a limit violation together with a page fault. The outcome there depends only on the priority order. Random stimulus seldom lines up all the conditions, so directed vectors stack them on purpose. Long random runs then mix the modes, segments and address classes, which include the values exactly at the 16-bit limit and at both sides of the canonical boundary. The bench's own reference model checks each verdict every cycle.

// File: rtl/flush_dec_pkg.sv
package flush_dec_pkg;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_V86  = 2'd1,
    MODE_PROT = 2'd2,
    MODE_LONG = 2'd3
  } execMode_t;

  typedef enum logic [2:0] {
    FK_NONE = 3'd0,
    FK_UD   = 3'd1,
    FK_GP   = 3'd2,
    FK_SS   = 3'd3,
    FK_PF   = 3'd4
  } faultKind_t;

  localparam logic [7:0] OPC_ESCAPE = 8'h0F;
  localparam logic [7:0] OPC_GROUP  = 8'hAE;
  localparam logic [2:0] REG_FLUSH  = 3'd7;
  localparam logic [1:0] MOD_REG    = 2'b11;
  localparam logic [2:0] SEG_STACK  = 3'd2;

  localparam logic [7:0] VEC_UD = 8'd6;
  localparam logic [7:0] VEC_SS = 8'd12;
  localparam logic [7:0] VEC_GP = 8'd13;
  localparam logic [7:0] VEC_PF = 8'd14;

  typedef struct packed {
    logic       takeFlush;
    logic       takeFault;
    faultKind_t kind;
  } ctlStrobe_t;

  function automatic logic [7:0] vectorOf(faultKind_t k);
    case (k)
      FK_UD:   return VEC_UD;
      FK_GP:   return VEC_GP;
      FK_SS:   return VEC_SS;
      FK_PF:   return VEC_PF;
      default: return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/flush_dec_datapath.sv
module flush_dec_datapath
  import flush_dec_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int VA_BITS   = 48,
  parameter int REAL_BITS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] effAddr,
  input  execMode_t         execMode,
  input  logic [2:0]        segId,
  input  logic              segLimitFault,
  input  logic              segReadable,
  input  logic              segExecOnly,
  input  ctlStrobe_t        ctl,
  output logic              addrFault,
  output logic              addrFaultStack,
  output logic              flushValid,
  output logic [ADDR_W-1:0] flushAddr,
  output logic              faultValid,
  output faultKind_t        faultKind,
  output logic [7:0]        faultVector
);

  localparam int UPPER_LSB = VA_BITS - 1;

  logic realOutside;
  logic nonCanonical;
  logic protViolation;
  logic stackSeg;

  generate
    if (REAL_BITS < ADDR_W) begin : gRealChk
      assign realOutside = |effAddr[ADDR_W-1:REAL_BITS];
    end else begin : gRealNone
      assign realOutside = 1'b0;
    end
  endgenerate

  generate
    if (VA_BITS < ADDR_W) begin : gCanonChk
      logic [ADDR_W-1-UPPER_LSB:0] upperBits;
      assign upperBits    = effAddr[ADDR_W-1:UPPER_LSB];
      assign nonCanonical = !((&upperBits) || !(|upperBits));
    end else begin : gCanonNone
      assign nonCanonical = 1'b0;
    end
  endgenerate

  // Execute-only segments are accepted; other unreadable segments fault.
  assign protViolation = segLimitFault || (!segReadable && !segExecOnly);
  assign stackSeg      = (segId == SEG_STACK);

  always_comb begin
    addrFault      = 1'b0;
    addrFaultStack = 1'b0;
    case (execMode)
      MODE_REAL, MODE_V86: begin
        addrFault = realOutside;
      end
      MODE_PROT: begin
        addrFault      = protViolation;
        addrFaultStack = protViolation && stackSeg;
      end
      MODE_LONG: begin
        addrFault      = nonCanonical;
        addrFaultStack = nonCanonical && stackSeg;
      end
      default: begin
        addrFault = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushValid  <= 1'b0;
      flushAddr   <= '0;
      faultValid  <= 1'b0;
      faultKind   <= FK_NONE;
      faultVector <= 8'd0;
    end else begin
      flushValid <= ctl.takeFlush;
      faultValid <= ctl.takeFault;
      if (ctl.takeFlush) begin
        flushAddr <= effAddr;
      end
      if (ctl.takeFault) begin
        faultKind   <= ctl.kind;
        faultVector <= vectorOf(ctl.kind);
      end else begin
        faultKind   <= FK_NONE;
        faultVector <= 8'd0;
      end
    end
  end

endmodule

// File: rtl/flush_dec_control.sv
module flush_dec_control
  import flush_dec_pkg::*;
(
  input  logic       inValid,
  input  logic       pfxOpSize,
  input  logic       pfxLock,
  input  logic       pfxRepz,
  input  logic       pfxRepnz,
  input  logic [7:0] opByte0,
  input  logic [7:0] opByte1,
  input  logic [4:0] modrmHi,
  input  execMode_t  execMode,
  input  logic       featEn,
  input  logic       addrFault,
  input  logic       addrFaultStack,
  input  logic       pageFault,
  output ctlStrobe_t ctl
);

  logic claimed;
  logic undefHit;
  logic pageHit;

  assign claimed = pfxOpSize
                && (opByte0 == OPC_ESCAPE)
                && (opByte1 == OPC_GROUP)
                && (modrmHi[2:0] == REG_FLUSH)
                && (modrmHi[4:3] != MOD_REG);

  assign undefHit = !featEn || pfxLock || pfxRepz || pfxRepnz;
  assign pageHit  = pageFault && (execMode != MODE_REAL);

  always_comb begin
    ctl = '{takeFlush: 1'b0, takeFault: 1'b0, kind: FK_NONE};
    if (inValid && claimed) begin
      if (undefHit) begin
        ctl.takeFault = 1'b1;
        ctl.kind      = FK_UD;
      end else if (addrFault) begin
        ctl.takeFault = 1'b1;
        ctl.kind      = addrFaultStack ? FK_SS : FK_GP;
      end else if (pageHit) begin
        ctl.takeFault = 1'b1;
        ctl.kind      = FK_PF;
      end else begin
        ctl.takeFlush = 1'b1;
      end
    end
  end

endmodule

// File: rtl/flush_insn_decoder.sv
module flush_insn_decoder
  import flush_dec_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int VA_BITS = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              pfxOpSize,
  input  logic              pfxLock,
  input  logic              pfxRepz,
  input  logic              pfxRepnz,
  input  logic [7:0]        opByte0,
  input  logic [7:0]        opByte1,
  input  logic [7:0]        modrm,
  input  logic [1:0]        execMode,
  input  logic              featEn,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [2:0]        segId,
  input  logic              segLimitFault,
  input  logic              segReadable,
  input  logic              segExecOnly,
  input  logic              pageFault,
  output logic              flushValid,
  output logic [ADDR_W-1:0] flushAddr,
  output logic              faultValid,
  output logic [2:0]        faultKind,
  output logic [7:0]        faultVector
);

  execMode_t  modeT;
  ctlStrobe_t ctl;
  faultKind_t kindT;
  logic       addrFault;
  logic       addrFaultStack;

  assign modeT     = execMode_t'(execMode);
  assign faultKind = kindT;

  flush_dec_control ctrl_i (
    .inValid        (inValid),
    .pfxOpSize      (pfxOpSize),
    .pfxLock        (pfxLock),
    .pfxRepz        (pfxRepz),
    .pfxRepnz       (pfxRepnz),
    .opByte0        (opByte0),
    .opByte1        (opByte1),
    .modrmHi        (modrm[7:3]),
    .execMode       (modeT),
    .featEn         (featEn),
    .addrFault      (addrFault),
    .addrFaultStack (addrFaultStack),
    .pageFault      (pageFault),
    .ctl            (ctl)
  );

  flush_dec_datapath #(
    .ADDR_W  (ADDR_W),
    .VA_BITS (VA_BITS)
  ) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .effAddr        (effAddr),
    .execMode       (modeT),
    .segId          (segId),
    .segLimitFault  (segLimitFault),
    .segReadable    (segReadable),
    .segExecOnly    (segExecOnly),
    .ctl            (ctl),
    .addrFault      (addrFault),
    .addrFaultStack (addrFaultStack),
    .flushValid     (flushValid),
    .flushAddr      (flushAddr),
    .faultValid     (faultValid),
    .faultKind      (kindT),
    .faultVector    (faultVector)
  );

endmodule

// File: rtl/flush_dec_checker.sv
module flush_dec_checker #(
  parameter int ADDR_W  = 64,
  parameter int VA_BITS = 48
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              pfxLock,
  input logic              pfxRepz,
  input logic              pfxRepnz,
  input logic [7:0]        modrm,
  input logic [1:0]        execMode,
  input logic              featEn,
  input logic [ADDR_W-1:0] effAddr,
  input logic              flushValid,
  input logic [ADDR_W-1:0] flushAddr,
  input logic              faultValid,
  input logic [2:0]        faultKind
);

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    !(flushValid && faultValid)); // R9

  AST_VERDICT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (flushValid || faultValid) |-> $past(inValid)); // R9

  AST_FLUSH_NOT_REGFORM: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> $past(modrm[7:6] != 2'b11)); // R1

  AST_FLUSH_NEEDS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> $past(featEn && !pfxLock && !pfxRepz && !pfxRepnz)); // R2

  AST_REAL_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (flushValid && $past(execMode <= 2'd1)) |-> ($past(effAddr[ADDR_W-1:16]) == '0)); // R3

  AST_LONG_CANONICAL: assert property (@(posedge clk) disable iff (!rstN)
    (flushValid && $past(execMode == 2'd3)) |->
      ((&$past(effAddr[ADDR_W-1:VA_BITS-1])) || ($past(effAddr[ADDR_W-1:VA_BITS-1]) == '0))); // R4

  AST_REAL_NO_PAGEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && faultKind == 3'd4) |-> $past(execMode != 2'd0)); // R7

  AST_FLUSH_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> (flushAddr == $past(effAddr))); // R8

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !flushValid |-> $stable(flushAddr)); // R8

  AST_KIND_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |-> (faultKind == 3'd0)); // R9

endmodule

bind flush_insn_decoder flush_dec_checker #(
  .ADDR_W  (ADDR_W),
  .VA_BITS (VA_BITS)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .pfxLock    (pfxLock),
  .pfxRepz    (pfxRepz),
  .pfxRepnz   (pfxRepnz),
  .modrm      (modrm),
  .execMode   (execMode),
  .featEn     (featEn),
  .effAddr    (effAddr),
  .flushValid (flushValid),
  .flushAddr  (flushAddr),
  .faultValid (faultValid),
  .faultKind  (faultKind)
);

// File: tb/flush_insn_decoder_tb_top.sv
module flush_insn_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        pfxOpSize = 1'b0, pfxLock = 1'b0, pfxRepz = 1'b0, pfxRepnz = 1'b0;
  logic [7:0]  opByte0 = 8'h00, opByte1 = 8'h00, modrm = 8'h00;
  logic [1:0]  execMode = 2'd0;
  logic        featEn = 1'b0;
  logic [63:0] effAddr = 64'd0;
  logic [2:0]  segId = 3'd0;
  logic        segLimitFault = 1'b0, segReadable = 1'b0, segExecOnly = 1'b0, pageFault = 1'b0;
  logic        flushValid, faultValid;
  logic [63:0] flushAddr;
  logic [2:0]  faultKind;
  logic [7:0]  faultVector;

  int checks = 0;
  int fails  = 0;

  // expected state for the cycle after the last drive
  int          expKind = -1;
  logic [63:0] expAddr = 64'd0;
  string       curTag = "R10";

  always #10 clk = ~clk;

  flush_insn_decoder dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .pfxOpSize(pfxOpSize), .pfxLock(pfxLock), .pfxRepz(pfxRepz), .pfxRepnz(pfxRepnz),
    .opByte0(opByte0), .opByte1(opByte1), .modrm(modrm),
    .execMode(execMode), .featEn(featEn), .effAddr(effAddr), .segId(segId),
    .segLimitFault(segLimitFault), .segReadable(segReadable), .segExecOnly(segExecOnly),
    .pageFault(pageFault),
    .flushValid(flushValid), .flushAddr(flushAddr), .faultValid(faultValid),
    .faultKind(faultKind), .faultVector(faultVector)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // -1 not claimed, 0 flush, 1 UD, 2 GP, 3 SS, 4 PF
  function automatic int refKind();
    logic [16:0] hi;
    if (!(inValid && pfxOpSize && opByte0 == 8'h0F && opByte1 == 8'hAE &&
          modrm[5:3] == 3'd7 && modrm[7:6] != 2'b11)) return -1;
    if (!featEn || pfxLock || pfxRepz || pfxRepnz) return 1;
    if (execMode <= 2'd1) begin
      if (effAddr > 64'hFFFF) return 2;
    end else if (execMode == 2'd2) begin
      if (segLimitFault || (!segReadable && !segExecOnly)) return (segId == 3'd2) ? 3 : 2;
    end else begin
      hi = effAddr[63:47];
      if (!(hi == 17'd0 || hi == 17'h1FFFF)) return (segId == 3'd2) ? 3 : 2;
    end
    if (pageFault && execMode != 2'd0) return 4;
    return 0;
  endfunction

  function automatic logic [7:0] refVec(int k);
    case (k)
      1: return 8'd6;
      2: return 8'd13;
      3: return 8'd12;
      4: return 8'd14;
      default: return 8'd0;
    endcase
  endfunction

  task automatic compareNow();
    logic eFlush, eFault;
    eFlush = (expKind == 0);
    eFault = (expKind > 0);
    chk(curTag, "flushValid", {63'd0, flushValid}, {63'd0, eFlush});
    chk(curTag, "faultValid", {63'd0, faultValid}, {63'd0, eFault});
    chk(curTag, "faultKind", {61'd0, faultKind}, eFault ? 64'(expKind) : 64'd0);
    chk(curTag, "faultVector", {56'd0, faultVector}, {56'd0, refVec(expKind)});
    chk(curTag, "flushAddr", flushAddr, expAddr);
  endtask

  task automatic settle(input string tag);
    expKind = refKind();
    if (expKind == 0) expAddr = effAddr;
    curTag = tag;
  endtask

  task automatic vec(input string tag, input logic op, input logic lk, input logic rz, input logic rnz,
                     input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] mr,
                     input logic [1:0] md, input logic fe, input logic [63:0] ad, input logic [2:0] sg,
                     input logic lf, input logic rd, input logic xo, input logic pf);
    @(negedge clk);
    compareNow();
    inValid = 1'b1; pfxOpSize = op; pfxLock = lk; pfxRepz = rz; pfxRepnz = rnz;
    opByte0 = b0; opByte1 = b1; modrm = mr; execMode = md; featEn = fe; effAddr = ad;
    segId = sg; segLimitFault = lf; segReadable = rd; segExecOnly = xo; pageFault = pf;
    settle(tag);
  endtask

  // a plain legal flush in the given mode, address and segment
  task automatic ok(input string tag, input logic [1:0] md, input logic [63:0] ad, input logic [2:0] sg,
                    input logic lf, input logic rd, input logic xo, input logic pf);
    vec(tag, 1, 0, 0, 0, 8'h0F, 8'hAE, 8'h38, md, 1, ad, sg, lf, rd, xo, pf);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    compareNow();
    inValid = 1'b0;
    effAddr = 64'hDEAD_0000_BEEF_0000;
    settle(tag);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compareNow(); // R10 during reset
    rstN = 1'b1;
    idle("R10");

    // R8 basic flushes, protected and 64-bit
    ok("R8", 2'd2, 64'h0000_1234, 3'd3, 0, 1, 0, 0);
    ok("R8", 2'd3, 64'h0000_7FFF_FFFF_FFC0, 3'd3, 0, 1, 0, 0);
    // R1 encodings that are not this instruction
    vec("R1", 0, 0, 0, 0, 8'h0F, 8'hAE, 8'h38, 2'd2, 1, 64'h40, 3'd3, 0, 1, 0, 0);
    vec("R1", 1, 0, 0, 0, 8'h0F, 8'hAF, 8'h38, 2'd2, 1, 64'h40, 3'd3, 0, 1, 0, 0);
    vec("R1", 1, 0, 0, 0, 8'h0E, 8'hAE, 8'h38, 2'd2, 1, 64'h40, 3'd3, 0, 1, 0, 0);
    vec("R1", 1, 0, 0, 0, 8'h0F, 8'hAE, 8'h30, 2'd2, 1, 64'h40, 3'd3, 0, 1, 0, 0);
    vec("R1", 1, 0, 0, 0, 8'h0F, 8'hAE, 8'hF8, 2'd2, 1, 64'h40, 3'd3, 0, 1, 0, 0);
    vec("R1", 1, 1, 0, 0, 8'h0F, 8'hAE, 8'hFF, 2'd2, 0, 64'h40, 3'd3, 0, 1, 0, 0);
    vec("R1", 1, 0, 0, 0, 8'h0F, 8'hAE, 8'hBC, 2'd2, 1, 64'h80, 3'd3, 0, 1, 0, 0);
    // R2 undefined-opcode causes, with stacked lower-priority faults
    vec("R2", 1, 0, 0, 0, 8'h0F, 8'hAE, 8'h38, 2'd2, 0, 64'h40, 3'd3, 0, 1, 0, 0);
    vec("R2", 1, 1, 0, 0, 8'h0F, 8'hAE, 8'h78, 2'd2, 1, 64'h40, 3'd3, 0, 1, 0, 0);
    vec("R2", 1, 0, 1, 0, 8'h0F, 8'hAE, 8'h38, 2'd0, 1, 64'h40, 3'd3, 0, 1, 0, 0);
    vec("R2", 1, 0, 0, 1, 8'h0F, 8'hAE, 8'h38, 2'd3, 1, 64'h40, 3'd3, 0, 1, 0, 0);
    vec("R2", 1, 1, 0, 0, 8'h0F, 8'hAE, 8'h38, 2'd3, 1, 64'h0000_8000_0000_0000, 3'd2, 0, 1, 0, 1);
    // R3 real and v86 address range
    ok("R3", 2'd0, 64'h0000_FFFF, 3'd3, 0, 0, 0, 0);
    ok("R3", 2'd0, 64'h0001_0000, 3'd3, 0, 1, 0, 0);
    ok("R3", 2'd1, 64'h0001_0000, 3'd2, 0, 1, 0, 1);
    ok("R3", 2'd1, 64'h8000_0000_0000_0000, 3'd3, 0, 1, 0, 0);
    // R4 canonical boundary
    ok("R4", 2'd3, 64'h0000_8000_0000_0000, 3'd3, 0, 1, 0, 0);
    ok("R4", 2'd3, 64'h0000_8000_0000_0000, 3'd2, 0, 1, 0, 1);
    ok("R4", 2'd3, 64'hFFFF_8000_0000_0000, 3'd2, 0, 1, 0, 0);
    ok("R4", 2'd3, 64'hFFFF_7FFF_FFFF_FFFF, 3'd0, 0, 1, 0, 0);
    ok("R4", 2'd3, 64'h0000_7FFF_FFFF_FFFF, 3'd2, 0, 1, 0, 0);
    // R5 protected-mode segment faults
    ok("R5", 2'd2, 64'h100, 3'd2, 1, 1, 0, 0);
    ok("R5", 2'd2, 64'h100, 3'd0, 1, 1, 0, 0);
    ok("R5", 2'd2, 64'h100, 3'd5, 0, 0, 0, 0);
    ok("R5", 2'd2, 64'h100, 3'd2, 0, 0, 0, 1);
    // R6 execute-only segment accepted
    ok("R6", 2'd2, 64'h0ABC_DE00, 3'd1, 0, 0, 1, 0);
    ok("R6", 2'd2, 64'h0ABC_DE40, 3'd1, 1, 0, 1, 0);
    // R7 page fault per mode and priority
    ok("R7", 2'd2, 64'h200, 3'd3, 0, 1, 0, 1);
    ok("R7", 2'd3, 64'h200, 3'd3, 0, 1, 0, 1);
    ok("R7", 2'd1, 64'h200, 3'd3, 0, 1, 0, 1);
    ok("R7", 2'd0, 64'h0300, 3'd3, 0, 1, 0, 1);
    ok("R7", 2'd2, 64'h200, 3'd3, 1, 1, 0, 1);
    // R11 segment inputs ignored outside protected mode
    ok("R11", 2'd3, 64'h0440, 3'd2, 1, 0, 0, 0);
    ok("R11", 2'd0, 64'h0480, 3'd2, 1, 0, 0, 0);
    ok("R11", 2'd1, 64'h04C0, 3'd2, 1, 0, 0, 0);
    // R8 address holds across a fault and idle
    ok("R8", 2'd2, 64'h100, 3'd0, 1, 1, 0, 0);
    idle("R8");
    // R9 back-to-back then idle
    ok("R9", 2'd2, 64'h900, 3'd3, 0, 1, 0, 0);
    ok("R9", 2'd2, 64'h940, 3'd3, 0, 1, 0, 1);
    idle("R9");
    idle("R9");

    // random mix, checked against the reference model every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] ad;
      logic [7:0]  mr;
      int          sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: ad = 64'($urandom_range(0, 32'h1_FFFF));
        1: ad = 64'hFFFF;
        2: ad = {17'h1FFFF, 15'($urandom), 32'($urandom)};
        3: ad = {17'h00000, 15'($urandom), 32'($urandom)};
        4: ad = {32'($urandom), 32'($urandom)};
        default: ad = 64'h0000_8000_0000_0000;
      endcase
      mr = 8'($urandom);
      if ($urandom_range(0, 3) != 0) mr[5:3] = 3'd7;
      if ($urandom_range(0, 4) == 0) begin
        idle("R9");
      end else begin
        vec("R9", $urandom_range(0, 7) != 0, $urandom_range(0, 9) == 0,
            $urandom_range(0, 11) == 0, $urandom_range(0, 11) == 0,
            ($urandom_range(0, 15) == 0) ? 8'($urandom) : 8'h0F,
            ($urandom_range(0, 15) == 0) ? 8'($urandom) : 8'hAE,
            mr, 2'($urandom), $urandom_range(0, 9) != 0, ad,
            3'($urandom_range(0, 5)), $urandom_range(0, 5) == 0,
            $urandom_range(0, 3) != 0, 1'($urandom), $urandom_range(0, 5) == 0);
      end
    end
    idle("R9");
    idle("R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule